// File: doc/BRIEF.md
# Five-Function Integer ALU

A purely combinational integer arithmetic logic unit of parameterised width (32 bits by default). Two operands and a 3-bit function code go in. The result comes out together with three flags: a zero flag, a signed-overflow flag and a carry-out. The unit performs bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison.

There is one adder path. Subtraction and the comparison do not use a separate subtractor. The top bit of the function code inverts the second operand and also supplies the adder's carry-in, so the adder computes A + ~B + 1. The comparison takes that same subtraction and reduces it to a single result bit.

The unit has no storage. It is meant to sit in the execute stage of an integer datapath, and any register on its inputs or outputs belongs to the surrounding pipeline.

Top module: `alu_fivefn`

## Requirements
- R1: Function code 3'b000 gives result = A & B.
- R2: Function code 3'b001 gives result = A | B.
- R3: Function code 3'b010 gives result = A + B modulo 2^WIDTH, and carry-out is bit WIDTH of the unsigned sum.
- R4: Function code 3'b110 gives result = A + ~B + 1 (that is, A − B modulo 2^WIDTH). Carry-out is bit WIDTH of that sum, so it is 1 exactly when A ≥ B as unsigned values.
- R5: For codes 3'b010, 3'b110 and 3'b111, the overflow flag is the carry into the most significant bit XOR the carry out of it. This flag is 1 exactly when the signed sum or difference does not fit in WIDTH bits.
- R6: Function code 3'b111 gives result bit 0 = 1 exactly when A < B as signed two's-complement numbers, including when A − B overflows. Every other result bit is 0. Overflow and carry-out are those of the subtraction A − B.
- R7: The zero flag is 1 exactly when every result bit is 0, for every function code.
- R8: For codes 3'b000 and 3'b001, the overflow flag and the carry-out are both 0.
- R9: The unused codes 3'b011, 3'b100 and 3'b101 give a result of all zeros, with overflow 0 and carry-out 0. The zero flag is therefore 1 for these codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| fsel | input | 3 | Function code |
| res | output | WIDTH | Result |
| zero | output | 1 | 1 when the result is all zeros |
| ovf | output | 1 | Signed overflow of the adder path |
| cout | output | 1 | Carry out of the most significant adder bit |

## Verification
Some properties are checked by the bound checker on every input change:
- the zero flag against the result;
- the cleared upper bits in a comparison;
- the cleared flags for the logic operations and the unused codes;
- the arithmetic identities of addition, subtraction and signed comparison.

Other behaviour can only be shown by the bench's scenarios. These are the exact overflow and carry values at the wrap-around corners: most negative minus one, most positive plus one, equal operands, and a comparison whose subtraction overflows. The bench also checks them against a reference model written independently, over thousands of random operand pairs.

// File: rtl/alu_fivefn.sv
module alu_fivefn #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       fsel,
  output logic [WIDTH-1:0] res,
  output logic             zero,
  output logic             ovf,
  output logic             cout
);

  localparam logic [2:0] F_AND = 3'b000;
  localparam logic [2:0] F_OR  = 3'b001;
  localparam logic [2:0] F_ADD = 3'b010;
  localparam logic [2:0] F_SUB = 3'b110;
  localparam logic [2:0] F_SLT = 3'b111;

  logic             neg_b;
  logic [WIDTH-1:0] bx;
  logic [WIDTH-2:0] sum_lo;
  logic             c_msb;
  logic             sum_hi;
  logic             c_top;
  logic             ovf_raw;
  logic             less;

  assign neg_b = fsel[2];
  assign bx    = neg_b ? ~opb : opb;

  assign {c_msb, sum_lo} = {1'b0, opa[WIDTH-2:0]} + {1'b0, bx[WIDTH-2:0]}
                         + {{(WIDTH-1){1'b0}}, neg_b};
  assign {c_top, sum_hi} = {1'b0, opa[WIDTH-1]} + {1'b0, bx[WIDTH-1]} + {1'b0, c_msb};

  assign ovf_raw = c_msb ^ c_top;
  assign less    = sum_hi ^ ovf_raw;

  always_comb begin
    res  = '0;
    ovf  = 1'b0;
    cout = 1'b0;
    unique case (fsel)
      F_AND: res = opa & opb;
      F_OR:  res = opa | opb;
      F_ADD, F_SUB: begin
        res  = {sum_hi, sum_lo};
        ovf  = ovf_raw;
        cout = c_top;
      end
      F_SLT: begin
        res  = {{(WIDTH-1){1'b0}}, less};
        ovf  = ovf_raw;
        cout = c_top;
      end
      default: ;
    endcase
  end

  assign zero = ~|res;

endmodule

module alu_fivefn_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       fsel,
  input logic [WIDTH-1:0] res,
  input logic             zero,
  input logic             ovf,
  input logic             cout
);

  always_comb begin
    // R7
    zero_flag_chk: assert (zero == (res == '0));
    // R6
    if (fsel == 3'b111) slt_upper_chk: assert (res[WIDTH-1:1] == '0);
    // R6
    if (fsel == 3'b111) slt_value_chk: assert (res[0] == ($signed(opa) < $signed(opb)));
    // R8
    if (fsel[2:1] == 2'b00) logic_flags_chk: assert (!ovf && !cout);
    // R9
    if (fsel == 3'b011 || fsel == 3'b100 || fsel == 3'b101)
      unused_code_chk: assert (res == '0 && !ovf && !cout && zero);
    // R3
    if (fsel == 3'b010) add_sum_chk: assert ({cout, res} == {1'b0, opa} + {1'b0, opb});
    // R4
    if (fsel == 3'b110) sub_diff_chk: assert (res == opa - opb && cout == (opa >= opb));
    // R1
    if (fsel == 3'b000) and_val_chk: assert (res == (opa & opb));
    // R2
    if (fsel == 3'b001) or_val_chk: assert (res == (opa | opb));
  end

endmodule

bind alu_fivefn alu_fivefn_chk #(.WIDTH(WIDTH)) u_chk (
  .opa(opa), .opb(opb), .fsel(fsel), .res(res),
  .zero(zero), .ovf(ovf), .cout(cout)
);

// File: tb/test_alu_fivefn.sv
module test_alu_fivefn;
  localparam int W = 32;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, r;
  logic [2:0]   f;
  logic         z, v, c;
  int checks = 0, fails = 0;
  bit done = 0;

  alu_fivefn #(.WIDTH(W)) i_alu_fivefn (
    .opa(a), .opb(b), .fsel(f), .res(r), .zero(z), .ovf(v), .cout(c)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [W+2:0] ref_model(input logic [2:0] op,
                                             input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    logic [W-1:0] rr;
    logic ov, cy, sx, sy;
    rr = '0; ov = 1'b0; cy = 1'b0;
    sx = x[W-1]; sy = y[W-1];
    case (op)
      3'b000: rr = x & y;
      3'b001: rr = x | y;
      3'b010: begin
        s = {1'b0, x} + {1'b0, y};
        rr = s[W-1:0]; cy = s[W];
        ov = (sx == sy) && (rr[W-1] != sx);
      end
      3'b110, 3'b111: begin
        s = {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, 1'b1};
        cy = s[W];
        ov = (sx != sy) && (s[W-1] != sx);
        if (op == 3'b110) rr = s[W-1:0];
        else rr = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      end
      default: ;
    endcase
    return {rr, (rr == '0), ov, cy};
  endfunction

  task automatic check(input logic [2:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W+2:0] e;
    string rq;
    @(negedge clk);
    f = op; a = x; b = y;
    #1;
    e = ref_model(op, x, y);
    rq = req_of(op);
    checks++;
    if (r !== e[W+2:3]) begin
      fails++;
      $display("FAIL %s result op=%b a=%h b=%h got %h exp %h", rq, op, x, y, r, e[W+2:3]);
    end
    checks++;
    if (z !== e[2]) begin
      fails++;
      $display("FAIL R7 zero op=%b got %b exp %b", op, z, e[2]);
    end
    checks++;
    if (v !== e[1]) begin
      fails++;
      $display("FAIL %s overflow op=%b a=%h b=%h got %b exp %b",
               (op[2:1] == 2'b00) ? "R8" : "R5", op, x, y, v, e[1]);
    end
    checks++;
    if (c !== e[0]) begin
      fails++;
      $display("FAIL %s carry op=%b a=%h b=%h got %b exp %b",
               (op[2:1] == 2'b00) ? "R8" : rq, op, x, y, c, e[0]);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; f = 3'b000;
    void'($urandom(32'd20240517));
    // R7: all-zero inputs give zero result
    check(3'b000, '0, '0);
    // R5 R4: most negative minus one overflows
    check(3'b110, MINN, 1);
    // R5 R3: max positive plus one overflows
    check(3'b010, MAXP, 1);
    // R3: unsigned wrap sets carry
    check(3'b010, '1, 1);
    // R4 R7: equal operands
    check(3'b110, 32'h1234_5678, 32'h1234_5678);
    // R6: equal operands compare false
    check(3'b111, 32'h8000_0005, 32'h8000_0005);
    // R6: overflowing subtraction still compares correctly
    check(3'b111, MINN, 1);
    check(3'b111, MAXP, '1);
    check(3'b111, '1, 0);
    // R1 R2 R8
    check(3'b000, 32'hF0F0_F0F0, 32'h0FF0_0FF0);
    check(3'b001, 32'hF0F0_0000, 32'h0000_0F0F);
    // R9: unused codes
    check(3'b011, '1, '1);
    check(3'b100, 32'h1, 32'h2);
    check(3'b101, MAXP, MINN);
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] x, y;
      logic [2:0] op;
      x = $urandom; y = $urandom;
      op = 3'($urandom);
      if (i % 7 == 0) y = x;
      if (i % 11 == 0) x = (i % 2 == 0) ? MINN : MAXP;
      check(op, x, y);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule